// File: doc/BRIEF.md
# Bidirectional 8-bit Timer Counter

This block is an 8-bit count register. It advances only on a timer tick, and the tick is produced inside the block. A 3-bit source selector either stops the tick or derives it from a base rate through a free-running prescaler. The base rate is the system clock, or the rising edges of an external input once a source-select bit is set. The external input is synchronized into the system clock domain and turned into a one-cycle pulse before it is used.

A 2-bit mode picks the counting style and the limit. In the up-only styles the counter climbs to its limit and falls back to zero. In the up/down styles it climbs to the limit and then descends to zero, turning at each end. The limit is either the all-ones maximum or a compare value supplied on a port. Two combinational flags report that the count equals the limit and that it equals zero. A sticky overflow request marks each up-only wrap. Software can load the count at any time and read it back continuously, including while the timer is stopped.

Top module: `timer8_unit`

## Requirements
- R1: After reset the count is 0x00, the direction is up, the overflow request is clear, bottom_o is 1 and, in mode 0, top_o is 0.
- R2: bottom_o is 1 exactly when the count is 0x00. top_o is 1 exactly when the count equals the limit. The limit is 0xFF when mode bit 0 is 0 and cmp_val when mode bit 0 is 1.
- R3: In mode 0 (up, limit 0xFF) each tick adds one to the count, and a tick at 0xFF gives 0x00.
- R4: With tick_sel = 0 no tick occurs and the count holds its value.
- R5: A cnt_wr pulse loads cnt_wdata on the next clock edge whatever tick_sel is. cnt_rdata always shows the count.
- R6: ovf_o is set by every up-only tick that returns the count to 0x00. It stays set until a cycle with ovf_clr = 1. If a set and a clear fall in the same cycle, the set wins.
- R7: In mode 1 (up, limit cmp_val) a tick at the limit gives 0x00. A tick below the limit adds one.
- R8: In modes 2 and 3 (up/down) the count rises to the limit, then falls one step per tick to 0x00, then rises again. dir_down_o is 1 while descending. These modes never set ovf_o.
- R9: A cnt_wr in the same cycle as a tick loads cnt_wdata. The tick is lost.
- R10: The tick_sel values 1 to 7 give one tick every 1, 8, 32, 64, 128, 256 and 1024 base ticks, taken from a free-running prescaler.
- R11: With src_ext = 1 the base tick is each rising edge of ext_clk_in, counted 3 system clock edges after the edge arrives. With tick_sel = 1, a level held steady adds nothing.
- R12: In modes 0 and 1 the direction is forced to up on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Bit 1: up/down style; bit 0: limit from cmp_val |
| tick_sel | input | 3 | 0 stops the timer; 1 to 7 choose the prescale ratio |
| src_ext | input | 1 | 1 selects the external input as the base rate |
| ext_clk_in | input | 1 | Raw external clock level |
| cmp_val | input | 8 | Programmable limit |
| cnt_wr | input | 1 | Count write strobe |
| cnt_wdata | input | 8 | Count write data |
| ovf_clr | input | 1 | Write-one clear of the overflow request |
| cnt_rdata | output | 8 | Current count |
| top_o | output | 1 | Count equals the limit |
| bottom_o | output | 1 | Count equals zero |
| dir_down_o | output | 1 | Counter is descending |
| ovf_o | output | 1 | Sticky overflow request |

## Verification
Two pairs of functions can act in the same cycle. A software load can meet a tick, and an overflow set can meet a write-one clear. The bench provokes the first by raising cnt_wr on a clock edge where the counter is running every cycle. It then expects the written value, not the value plus one, and one cycle later the value plus one. It provokes the second by starting the count at 0xFF with ovf_clr held high for the same edge that wraps the count, and expects ovf_o to read 1 afterwards.

// File: rtl/timer8_pkg.sv
package timer8_pkg;

  // bit 1: up/down style, bit 0: limit from compare value
  typedef enum logic [1:0] {
    MODE_UP_MAX   = 2'b00,
    MODE_UP_CMP   = 2'b01,
    MODE_UPDN_MAX = 2'b10,
    MODE_UPDN_CMP = 2'b11
  } tmr_mode_e;

  localparam int unsigned PRE_W = 10;

  // mask of prescaler bits that must all be one for a tick
  function automatic logic [PRE_W-1:0] sel_mask(input logic [2:0] sel);
    logic [PRE_W-1:0] m;
    case (sel)
      3'd2:    m = PRE_W'(10'h007);
      3'd3:    m = PRE_W'(10'h01F);
      3'd4:    m = PRE_W'(10'h03F);
      3'd5:    m = PRE_W'(10'h07F);
      3'd6:    m = PRE_W'(10'h0FF);
      3'd7:    m = PRE_W'(10'h3FF);
      default: m = '0;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/timer8_ext_sync.sv
module timer8_ext_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_in,
  output logic edge_pulse
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[i] <= 1'b0;
          else        sync_q[i] <= ext_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[i] <= 1'b0;
          else        sync_q[i] <= sync_q[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= sync_q[STAGES-1];
  end

  assign edge_pulse = sync_q[STAGES-1] & ~last_q;

  AST_EXT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    edge_pulse |=> !edge_pulse); // R11

endmodule

// File: rtl/timer8_tick_gen.sv
module timer8_tick_gen
  import timer8_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] tick_sel,
  input  logic       src_ext,
  input  logic       ext_pulse,
  output logic       tick
);
  logic [PRE_W-1:0] pre_q;
  logic             base_tick;
  logic [PRE_W-1:0] mask;

  assign base_tick = src_ext ? ext_pulse : 1'b1;
  assign mask      = sel_mask(tick_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pre_q <= '0;
    else if (base_tick) pre_q <= pre_q + 1'b1;
  end

  assign tick = base_tick && (tick_sel != 3'd0) && ((pre_q & mask) == mask);

  AST_STOPPED_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_sel == 3'd0) |-> !tick); // R4

  AST_EXT_GATES_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (src_ext && !ext_pulse) |-> !tick); // R11

endmodule

// File: rtl/timer8_count_core.sv
module timer8_count_core
  import timer8_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [1:0]       mode,
  input  logic [CNT_W-1:0] cmp_val,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  input  logic             ovf_clr,
  output logic [CNT_W-1:0] cnt,
  output logic             dir_down,
  output logic             ovf,
  output logic             at_top,
  output logic             at_bottom
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  tmr_mode_e        mode_e;
  logic             updn;
  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] cnt_n;
  logic             dir_n;
  logic             ovf_set;

  assign mode_e    = tmr_mode_e'(mode);
  assign updn      = (mode_e == MODE_UPDN_MAX) || (mode_e == MODE_UPDN_CMP);
  assign limit     = mode[0] ? cmp_val : CNT_MAX;
  assign at_top    = (cnt == limit);
  assign at_bottom = (cnt == '0);

  always_comb begin
    cnt_n   = cnt;
    dir_n   = updn ? dir_down : 1'b0;
    ovf_set = 1'b0;
    if (wr) begin
      cnt_n = wdata;
    end else if (tick) begin
      if (!updn) begin
        if (at_top || cnt == CNT_MAX) begin
          cnt_n   = '0;
          ovf_set = 1'b1;
        end else begin
          cnt_n = cnt + CNT_ONE;
        end
      end else if (!dir_down) begin
        if (cnt >= limit) begin
          if (!at_bottom) begin
            cnt_n = cnt - CNT_ONE;
            dir_n = 1'b1;
          end
        end else begin
          cnt_n = cnt + CNT_ONE;
        end
      end else begin
        if (at_bottom) begin
          if (limit != '0) begin
            cnt_n = CNT_ONE;
            dir_n = 1'b0;
          end
        end else begin
          cnt_n = cnt - CNT_ONE;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      dir_down <= 1'b0;
      ovf      <= 1'b0;
    end else begin
      cnt      <= cnt_n;
      dir_down <= dir_n;
      ovf      <= ovf_set | (ovf & ~ovf_clr);
    end
  end

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr) |=> $stable(cnt)); // R4

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (cnt == $past(wdata))); // R9

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !ovf_clr) |=> ovf); // R6

  AST_UPONLY_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr && !mode[1] && at_top) |=> (at_bottom && ovf)); // R7

  AST_UPDN_NO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[1] && !ovf) |=> !ovf); // R8

  AST_UPONLY_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode[1]) |=> !dir_down); // R12

endmodule

// File: rtl/timer8_unit.sv
module timer8_unit #(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic [2:0]       tick_sel,
  input  logic             src_ext,
  input  logic             ext_clk_in,
  input  logic [CNT_W-1:0] cmp_val,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             ovf_clr,
  output logic [CNT_W-1:0] cnt_rdata,
  output logic             top_o,
  output logic             bottom_o,
  output logic             dir_down_o,
  output logic             ovf_o
);
  logic ext_pulse;
  logic tick;

  timer8_ext_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .ext_in     (ext_clk_in),
    .edge_pulse (ext_pulse)
  );

  timer8_tick_gen u_tick (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_sel  (tick_sel),
    .src_ext   (src_ext),
    .ext_pulse (ext_pulse),
    .tick      (tick)
  );

  timer8_count_core #(.CNT_W(CNT_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .mode      (mode),
    .cmp_val   (cmp_val),
    .wr        (cnt_wr),
    .wdata     (cnt_wdata),
    .ovf_clr   (ovf_clr),
    .cnt       (cnt_rdata),
    .dir_down  (dir_down_o),
    .ovf       (ovf_o),
    .at_top    (top_o),
    .at_bottom (bottom_o)
  );

  AST_BOTTOM_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    bottom_o == (cnt_rdata == '0)); // R2

endmodule

// File: tb/timer8_unit_bench.sv
module timer8_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [2:0] tick_sel = 3'd0;
  logic       src_ext = 1'b0;
  logic       ext_clk_in = 1'b0;
  logic [7:0] cmp_val = 8'd0;
  logic       cnt_wr = 1'b0;
  logic [7:0] cnt_wdata = 8'd0;
  logic       ovf_clr = 1'b0;
  logic [7:0] cnt_rdata;
  logic       top_o, bottom_o, dir_down_o, ovf_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  timer8_unit u_timer8_unit (
    .clk(clk), .rst_n(rst_n), .mode(mode), .tick_sel(tick_sel),
    .src_ext(src_ext), .ext_clk_in(ext_clk_in), .cmp_val(cmp_val),
    .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .ovf_clr(ovf_clr),
    .cnt_rdata(cnt_rdata), .top_o(top_o), .bottom_o(bottom_o),
    .dir_down_o(dir_down_o), .ovf_o(ovf_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(input logic [7:0] v);
    cnt_wr = 1'b1; cnt_wdata = v;
    step(1);
    cnt_wr = 1'b0;
  endtask

  task automatic clear_ovf();
    ovf_clr = 1'b1; step(1); ovf_clr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 count", cnt_rdata, 0);
    chk("R1 ovf", ovf_o, 0);
    chk("R1 dir", dir_down_o, 0);
    chk("R1 bottom", bottom_o, 1);
    chk("R1 top", top_o, 0);
  endtask

  task automatic t_stopped_write();
    tick_sel = 3'd0;
    load(8'h37);
    chk("R5 load while stopped", cnt_rdata, 8'h37);
    step(20);
    chk("R4 hold while stopped", cnt_rdata, 8'h37);
  endtask

  task automatic t_up_max();
    mode = 2'd0;
    load(8'hFD);
    tick_sel = 3'd1;
    step(1); chk("R3 inc", cnt_rdata, 8'hFE);
    step(1); chk("R3 inc to max", cnt_rdata, 8'hFF);
    chk("R2 top at max", top_o, 1);
    step(1); chk("R3 wrap", cnt_rdata, 8'h00);
    chk("R2 bottom", bottom_o, 1);
    chk("R6 ovf set", ovf_o, 1);
    tick_sel = 3'd0;
    step(3);
    chk("R6 ovf sticky", ovf_o, 1);
    clear_ovf();
    chk("R6 ovf cleared", ovf_o, 0);
  endtask

  task automatic t_set_beats_clear();
    load(8'hFF);
    tick_sel = 3'd1; ovf_clr = 1'b1;
    step(1);
    tick_sel = 3'd0; ovf_clr = 1'b0;
    chk("R6 wrap with clear", cnt_rdata, 0);
    chk("R6 set wins over clear", ovf_o, 1);
    clear_ovf();
  endtask

  task automatic t_up_cmp();
    mode = 2'd1; cmp_val = 8'd5;
    load(8'd0);
    tick_sel = 3'd1;
    for (int i = 1; i <= 5; i++) begin
      step(1);
      chk("R7 count up to limit", cnt_rdata, i);
    end
    chk("R2 top at cmp", top_o, 1);
    step(1);
    chk("R7 clear after limit", cnt_rdata, 0);
    chk("R6 ovf on cmp wrap", ovf_o, 1);
    tick_sel = 3'd0;
    clear_ovf();
  endtask

  task automatic t_updn_cmp();
    int seq [8] = '{1, 2, 3, 2, 1, 0, 1, 2};
    mode = 2'd3; cmp_val = 8'd3;
    load(8'd0);
    tick_sel = 3'd1;
    for (int i = 0; i < 8; i++) begin
      step(1);
      chk("R8 up/down sequence", cnt_rdata, seq[i]);
      if (i == 3) chk("R8 descending", dir_down_o, 1);
      if (i == 6) chk("R8 ascending again", dir_down_o, 0);
    end
    tick_sel = 3'd0;
    chk("R8 no ovf", ovf_o, 0);
    mode = 2'd2;
    load(8'hFE);
    tick_sel = 3'd1;
    step(1); chk("R8 max limit reached", cnt_rdata, 8'hFF);
    chk("R2 top at max updn", top_o, 1);
    step(1); chk("R8 turn at max", cnt_rdata, 8'hFE);
    tick_sel = 3'd0;
    chk("R8 dir down", dir_down_o, 1);
    chk("R8 no ovf at max", ovf_o, 0);
    mode = 2'd0;
    step(1);
    chk("R12 dir forced up", dir_down_o, 0);
  endtask

  task automatic t_write_priority();
    mode = 2'd0;
    load(8'h10);
    tick_sel = 3'd1;
    step(2);
    cnt_wr = 1'b1; cnt_wdata = 8'h80;
    step(1);
    cnt_wr = 1'b0;
    chk("R9 write beats tick", cnt_rdata, 8'h80);
    step(1);
    chk("R9 count resumes", cnt_rdata, 8'h81);
    tick_sel = 3'd0;
  endtask

  task automatic t_prescale();
    load(8'd0);
    tick_sel = 3'd2; step(80); tick_sel = 3'd0;
    chk("R10 divide by 8", cnt_rdata, 10);
    load(8'd0);
    tick_sel = 3'd4; step(128); tick_sel = 3'd0;
    chk("R10 divide by 64", cnt_rdata, 2);
    load(8'd0);
    tick_sel = 3'd3; step(96); tick_sel = 3'd0;
    chk("R10 divide by 32", cnt_rdata, 3);
  endtask

  task automatic t_external();
    load(8'd0);
    src_ext = 1'b1; tick_sel = 3'd1;
    step(10);
    chk("R11 no edges no count", cnt_rdata, 0);
    for (int i = 0; i < 5; i++) begin
      ext_clk_in = 1'b1; step(4);
      ext_clk_in = 1'b0; step(4);
    end
    step(4);
    chk("R11 five edges counted", cnt_rdata, 5);
    ext_clk_in = 1'b1;
    step(2);
    chk("R11 latency not yet", cnt_rdata, 5);
    step(1);
    chk("R11 counted on third edge", cnt_rdata, 6);
    step(10);
    chk("R11 steady level adds nothing", cnt_rdata, 6);
    tick_sel = 3'd0; src_ext = 1'b0; ext_clk_in = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_stopped_write();
    t_up_max();
    t_set_beats_clear();
    t_up_cmp();
    t_updn_cmp();
    t_write_priority();
    t_prescale();
    t_external();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule